// File: doc/BRIEF.md
# Interval Fingerprint Checker

This block gates the retirement of instructions on a hash exchange between two cores that run the same program. Each retiring instruction hands in one 64-bit word that sums up its architectural effect, such as a register result or a store address and datum. The block folds these words into a 16-bit CRC. When an interval of a fixed number of instructions is complete, it closes the interval and sends the hash as a message to the partner core. That message also carries a 4-bit interval sequence number and the interval length. The instructions stay unretired until the partner's message for the same interval has arrived and has been compared.

When the two messages agree, the block gives a one-cycle release pulse and the interval retires for good. When they disagree in any field, it gives a one-cycle rollback pulse and drops everything that is outstanding. Execution then restarts from the oldest unchecked interval, with a fresh hash and the same sequence number. A serializing instruction closes its interval early and holds stall high until that interval has been checked. Up to two closed intervals may wait at once, and non-serializing work goes on while they wait. The partner's message may come at any time, and it may come before the local hash is ready.

Top module: `fp_interval_checker`

## Requirements
- R1: After reset, res_ready and rx_ready are high, and tx_valid, stall, release_pulse and rollback_pulse are low.
- R2: The fingerprint is a CRC-16 with polynomial 0x1021 and seed 0xFFFF, with no reflection and no final inversion. It is updated once per accepted word, bit 63 first.
- R3: An interval closes on its INTERVAL_LEN-th accepted word. Its message carries tx_len equal to the word count and tx_seq counting 0, 1, 2 … modulo 16 over the closed intervals.
- R4: A word accepted with res_serial high closes the interval at that word, with tx_len equal to the words so far. stall then stays high, and res_ready low, until that interval has been checked.
- R5: At most two closed intervals are outstanding. While two are outstanding, res_ready is low.
- R6: Messages leave in closing order. A message offered with tx_ready low stays unchanged until it is taken.
- R7: A partner message is taken into a one-entry holding register whenever it arrives, even before the local interval closes. rx_ready is low while that register is full.
- R8: When the held message equals the oldest sent local message in fingerprint, sequence number and length, release_pulse is high for exactly one cycle.
- R9: Any difference in those three fields gives a one-cycle rollback_pulse. All outstanding intervals and the partial interval are dropped, the hash restarts at the seed, and numbering resumes at the sequence number of the oldest dropped interval.
- R10: release_pulse and rollback_pulse are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | A retiring instruction's update word is offered |
| res_ready | output | 1 | Update word is accepted this cycle |
| res_data | input | 64 | Architectural update word |
| res_serial | input | 1 | Offered instruction is serializing |
| tx_valid | output | 1 | Fingerprint message offered to the partner |
| tx_ready | input | 1 | Transport takes the message |
| tx_fp | output | 16 | Local fingerprint |
| tx_seq | output | 4 | Interval sequence number |
| tx_len | output | LEN_W | Instructions in the interval |
| rx_valid | input | 1 | Partner message offered |
| rx_ready | output | 1 | Holding register is free |
| rx_fp | input | 16 | Partner fingerprint |
| rx_seq | input | 4 | Partner sequence number |
| rx_len | input | LEN_W | Partner interval length |
| release_pulse | output | 1 | Oldest interval checked and retired |
| rollback_pulse | output | 1 | Mismatch: re-execute from oldest interval |
| stall | output | 1 | Serializing instruction waits for its check |

## Verification
The bench builds the block with an interval length of 4, so that full intervals, early closes and the two-deep limit all fall within a few dozen words. The expected fingerprint of every interval is computed in the bench from the CRC definition. A mismatch is injected once in each of the three compared fields, and each time a partial interval is left in flight, so the rollback's discard and renumbering can be seen on the next message. The partner reply is sent both before and after the local message, so arrival order does not matter to the result.

// File: rtl/fp_interval_checker.sv
module fp_interval_checker #(
  parameter int INTERVAL_LEN = 32,
  parameter int DATA_W = 64,
  parameter int FP_W = 16,
  parameter int SEQ_W = 4,
  parameter logic [FP_W-1:0] POLY = 'h1021,
  parameter logic [FP_W-1:0] SEED = 'hFFFF,
  localparam int LEN_W = $clog2(INTERVAL_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_serial,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [FP_W-1:0]   tx_fp,
  output logic [SEQ_W-1:0]  tx_seq,
  output logic [LEN_W-1:0]  tx_len,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [FP_W-1:0]   rx_fp,
  input  logic [SEQ_W-1:0]  rx_seq,
  input  logic [LEN_W-1:0]  rx_len,
  output logic              release_pulse,
  output logic              rollback_pulse,
  output logic              stall
);

  function automatic logic [FP_W-1:0] crc_step(input logic [FP_W-1:0] c, input logic [DATA_W-1:0] d);
    logic [FP_W-1:0] r;
    r = c;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (r[FP_W-1] ^ d[i]) r = (r << 1) ^ POLY;
      else                  r = r << 1;
    end
    return r;
  endfunction

  logic [FP_W-1:0]  crc;
  logic [LEN_W-1:0] cnt;
  logic [SEQ_W-1:0] seq;
  logic             ser_wait;

  logic [1:0]       q_v, q_sent, q_ser;
  logic [FP_W-1:0]  q_fp  [2];
  logic [SEQ_W-1:0] q_seq [2];
  logic [LEN_W-1:0] q_len [2];

  logic [1:0]       d_v, d_sent, d_ser;
  logic [FP_W-1:0]  d_fp  [2];
  logic [SEQ_W-1:0] d_seq [2];
  logic [LEN_W-1:0] d_len [2];

  logic             hold_v;
  logic [FP_W-1:0]  hold_fp;
  logic [SEQ_W-1:0] hold_seq;
  logic [LEN_W-1:0] hold_len;

  logic rel_q, rb_q;

  logic hit, same, pop, rb_now, acc, close, tx_sel, tx_fire, rx_fire, wi;
  logic [FP_W-1:0] crc_nx;

  assign hit    = hold_v && q_v[0] && q_sent[0];
  assign same   = (hold_fp == q_fp[0]) && (hold_seq == q_seq[0]) && (hold_len == q_len[0]);
  assign pop    = hit && same;
  assign rb_now = hit && !same;

  assign res_ready = !q_v[1] && !ser_wait && !rb_now;
  assign acc       = res_valid && res_ready;
  assign close     = acc && (res_serial || cnt == LEN_W'(INTERVAL_LEN - 1));
  assign crc_nx    = crc_step(crc, res_data);

  assign tx_sel   = q_sent[0];
  assign tx_valid = q_v[tx_sel] && !q_sent[tx_sel] && !rb_now;
  assign tx_fp    = q_fp[tx_sel];
  assign tx_seq   = q_seq[tx_sel];
  assign tx_len   = q_len[tx_sel];
  assign tx_fire  = tx_valid && tx_ready;

  assign rx_ready = !hold_v;
  assign rx_fire  = rx_valid && rx_ready;

  assign release_pulse  = rel_q;
  assign rollback_pulse = rb_q;
  assign stall          = ser_wait;

  always_comb begin
    d_v = q_v;
    d_sent = q_sent;
    d_ser = q_ser;
    d_fp = q_fp;
    d_seq = q_seq;
    d_len = q_len;
    if (tx_fire) d_sent[tx_sel] = 1'b1;
    if (pop) begin
      d_v[0] = d_v[1];     d_sent[0] = d_sent[1];  d_ser[0] = d_ser[1];
      d_fp[0] = d_fp[1];   d_seq[0] = d_seq[1];    d_len[0] = d_len[1];
      d_v[1] = 1'b0;       d_sent[1] = 1'b0;
    end
    wi = d_v[0];
    if (close) begin
      d_v[wi]   = 1'b1;
      d_sent[wi] = 1'b0;
      d_ser[wi] = res_serial;
      d_fp[wi]  = crc_nx;
      d_seq[wi] = seq;
      d_len[wi] = cnt + 1'b1;
    end
    if (rb_now) begin
      d_v = '0;
      d_sent = '0;
    end
  end

  always_ff @(posedge clk) begin
    q_fp <= d_fp;
    q_seq <= d_seq;
    q_len <= d_len;
    if (rx_fire) begin
      hold_fp <= rx_fp;
      hold_seq <= rx_seq;
      hold_len <= rx_len;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_v <= '0;
      q_sent <= '0;
      q_ser <= '0;
      crc <= SEED;
      cnt <= '0;
      seq <= '0;
      ser_wait <= 1'b0;
      hold_v <= 1'b0;
      rel_q <= 1'b0;
      rb_q <= 1'b0;
    end else begin
      q_v <= d_v;
      q_sent <= d_sent;
      q_ser <= d_ser;
      rel_q <= pop;
      rb_q <= rb_now;
      if (pop || rb_now) hold_v <= 1'b0;
      else if (rx_fire)  hold_v <= 1'b1;
      if (rb_now) begin
        crc <= SEED;
        cnt <= '0;
        seq <= q_seq[0];
        ser_wait <= 1'b0;
      end else begin
        if (close) begin
          crc <= SEED;
          cnt <= '0;
          seq <= seq + 1'b1;
        end else if (acc) begin
          crc <= crc_nx;
          cnt <= cnt + 1'b1;
        end
        if (close && res_serial)  ser_wait <= 1'b1;
        else if (pop && q_ser[0]) ser_wait <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fp_interval_checker_sva.sv
module fp_interval_checker_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       res_valid,
  input logic       res_ready,
  input logic       res_serial,
  input logic       release_pulse,
  input logic       rollback_pulse,
  input logic       stall,
  input logic [1:0] q_v,
  input logic       hold_v
);

  p_excl_pulses_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(release_pulse && rollback_pulse));

  p_stall_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !res_ready);

  p_serial_stalls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && res_serial) |=> stall);

  p_full_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q_v[1] |-> !res_ready);

  p_compact_queue_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q_v[1] |-> q_v[0]);

  p_release_needs_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    release_pulse |-> $past(hold_v));

  p_rollback_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rollback_pulse |-> (q_v == 2'b00 && !hold_v));

endmodule

bind fp_interval_checker fp_interval_checker_sva u_sva (
  .clk(clk),
  .rst_n(rst_n),
  .res_valid(res_valid),
  .res_ready(res_ready),
  .res_serial(res_serial),
  .release_pulse(release_pulse),
  .rollback_pulse(rollback_pulse),
  .stall(stall),
  .q_v(q_v),
  .hold_v(hold_v)
);

// File: tb/fp_interval_checker_test.sv
module fp_interval_checker_test;
  localparam int CLK_PERIOD = 10;
  localparam int IL = 4;
  localparam int LW = $clog2(IL + 1);

  logic clk, rst_n;
  logic res_valid, res_ready, res_serial;
  logic [63:0] res_data;
  logic tx_valid, tx_ready;
  logic [15:0] tx_fp;
  logic [3:0] tx_seq;
  logic [LW-1:0] tx_len;
  logic rx_valid, rx_ready;
  logic [15:0] rx_fp;
  logic [3:0] rx_seq;
  logic [LW-1:0] rx_len;
  logic release_pulse, rollback_pulse, stall;

  fp_interval_checker #(.INTERVAL_LEN(IL)) uut (
    .clk(clk), .rst_n(rst_n),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .res_serial(res_serial),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_fp(tx_fp), .tx_seq(tx_seq), .tx_len(tx_len),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_fp(rx_fp), .rx_seq(rx_seq), .rx_len(rx_len),
    .release_pulse(release_pulse), .rollback_pulse(rollback_pulse), .stall(stall)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_bad = 0;
  int m_n = 0, rel_n = 0, rb_n = 0, both_n = 0;
  logic [15:0] m_fp [64];
  logic [3:0]  m_seq [64];
  logic [LW-1:0] m_len [64];

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (tx_valid && tx_ready && m_n < 64) begin
        m_fp[m_n] = tx_fp; m_seq[m_n] = tx_seq; m_len[m_n] = tx_len; m_n++;
      end
      if (release_pulse) rel_n++;
      if (rollback_pulse) rb_n++;
      if (release_pulse && rollback_pulse) both_n++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_w(input logic [15:0] c, input logic [63:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 63; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [63:0] pat(input int k);
    if (k == 0) return 64'h0;
    if (k == 1) return {64{1'b1}};
    return {32'(k * 32'h9E3779B9), 32'(k * 32'h7F4A7C15) ^ 32'hA5A5A5A5};
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #2;
  endtask

  task automatic push(input logic [63:0] d, input logic s);
    @(negedge clk);
    res_valid = 1'b1; res_data = d; res_serial = s;
    #2;
    while (!res_ready) begin @(negedge clk); #2; end
    @(negedge clk);
    res_valid = 1'b0; res_serial = 1'b0;
  endtask

  task automatic send_rx(input logic [15:0] f, input logic [3:0] s, input logic [LW-1:0] l);
    @(negedge clk);
    rx_valid = 1'b1; rx_fp = f; rx_seq = s; rx_len = l;
    #2;
    while (!rx_ready) begin @(negedge clk); #2; end
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic logic [15:0] crc_of(input int base, input int n);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int j = 0; j < n; j++) c = crc_w(c, pat(base + j));
    return c;
  endfunction

  task automatic feed(input int base, input int n, input logic ser_last);
    for (int j = 0; j < n; j++) push(pat(base + j), ser_last && j == n - 1);
  endtask

  task automatic wait_msgs(input int t);
    for (int i = 0; i < 200 && m_n < t; i++) tick(1);
  endtask
  task automatic wait_rel(input int t);
    for (int i = 0; i < 200 && rel_n < t; i++) tick(1);
  endtask
  task automatic wait_rb(input int t);
    for (int i = 0; i < 200 && rb_n < t; i++) tick(1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] e, held;
    int seqn, rel0, rb0;
    rst_n = 0; res_valid = 0; res_serial = 0; res_data = '0;
    tx_ready = 1; rx_valid = 0; rx_fp = '0; rx_seq = '0; rx_len = '0;
    tick(3);
    rst_n = 1;
    tick(1);
    chk("R1 res_ready", res_ready, 1);
    chk("R1 rx_ready", rx_ready, 1);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 stall", stall, 0);
    chk("R1 pulses", {release_pulse, rollback_pulse}, 0);

    // R2 R3 R8: full intervals over varied data
    for (int k = 0; k < 6; k++) begin
      feed(4 * k, IL, 1'b0);
      wait_msgs(k + 1);
      e = crc_of(4 * k, IL);
      chk("R2 fingerprint", m_fp[k], e);
      chk("R3 seq", m_seq[k], k);
      chk("R3 len", m_len[k], IL);
      send_rx(e, 4'(k), LW'(IL));
      wait_rel(k + 1);
      chk("R8 release count", rel_n, k + 1);
    end
    chk("R8 no rollback", rb_n, 0);

    // R7: partner message first
    e = crc_of(100, IL);
    send_rx(e, 4'd6, LW'(IL));
    tick(1);
    chk("R7 rx_ready held", rx_ready, 0);
    chk("R7 no early release", rel_n, 6);
    feed(100, IL, 1'b0);
    wait_rel(7);
    chk("R7 release after local", rel_n, 7);
    chk("R7 rx_ready free", rx_ready, 1);

    // R4: serializing closes early
    feed(200, 2, 1'b1);
    tick(2);
    chk("R4 stall", stall, 1);
    chk("R4 ready low", res_ready, 0);
    wait_msgs(8);
    chk("R4 len", m_len[7], 2);
    chk("R4 seq", m_seq[7], 7);
    chk("R4 fp", m_fp[7], crc_of(200, 2));
    tick(3);
    chk("R4 stall holds", stall, 1);
    send_rx(crc_of(200, 2), 4'd7, LW'(2));
    wait_rel(8);
    tick(1);
    chk("R4 stall cleared", stall, 0);
    chk("R4 ready back", res_ready, 1);

    // R6 R5: held message, two outstanding
    tx_ready = 0;
    feed(300, IL, 1'b0);
    tick(2);
    chk("R6 offered", tx_valid, 1);
    held = tx_fp;
    tick(3);
    chk("R6 stable", tx_fp, held);
    chk("R6 value", held, crc_of(300, IL));
    @(negedge clk); tx_ready = 1;
    feed(400, IL, 1'b0);
    wait_msgs(10);
    tick(1);
    chk("R5 ready low", res_ready, 0);
    chk("R6 order first", m_seq[8], 8);
    chk("R6 order second", m_seq[9], 9);
    send_rx(crc_of(300, IL), 4'd8, LW'(IL));
    wait_rel(9);
    tick(1);
    chk("R5 ready back", res_ready, 1);
    send_rx(crc_of(400, IL), 4'd9, LW'(IL));
    wait_rel(10);
    chk("R8 in order", rel_n, 10);

    // R9: mismatch in each field, with partial interval in flight
    seqn = 10;
    for (int v = 0; v < 3; v++) begin
      rel0 = rel_n; rb0 = rb_n;
      feed(500 + 50 * v, IL, 1'b0);
      wait_msgs(m_n + 1);
      push(pat(999), 1'b0);
      e = crc_of(500 + 50 * v, IL);
      if (v == 0) send_rx(e ^ 16'h0001, 4'(seqn), LW'(IL));
      else if (v == 1) send_rx(e, 4'(seqn + 1), LW'(IL));
      else send_rx(e, 4'(seqn), LW'(IL - 1));
      wait_rb(rb0 + 1);
      chk("R9 rollback", rb_n, rb0 + 1);
      chk("R9 no release", rel_n, rel0);
      feed(700 + 50 * v, IL, 1'b0);
      wait_msgs(m_n + 1);
      chk("R9 seq reused", m_seq[m_n - 1], seqn);
      chk("R9 fresh fp", m_fp[m_n - 1], crc_of(700 + 50 * v, IL));
      send_rx(crc_of(700 + 50 * v, IL), 4'(seqn), LW'(IL));
      wait_rel(rel0 + 1);
      chk("R9 retry released", rel_n, rel0 + 1);
      seqn++;
    end

    chk("R10 exclusive", both_n, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule